// File: doc/BRIEF.md
# Differential Clock Pair Enable and Stop Controller

This block decides, for each of a parameterised number of differential clock output pairs, whether the pair toggles normally, sits in a driven stop (true side high, complement low), or floats. Three kinds of input feed the decision. The first is the output clock, modelled here by an internal phase bit that toggles on every `clk` edge. The second is the board pins: a per-pair enable, a powerdown request, a stop request, and a strap that flips the active level of all three. The third is a set of register bits written by a serial management block: a per-pair enable, a per-pair free-running mark, and one float-or-drive choice each for stop and for powerdown.

Asynchronous pin requests are synchronised into `clk`. The stop and powerdown requests must also stay steady across two successive rising edges of the complement clock before they are accepted. Each pair is governed by a small state machine with six states: S_OFF (tri-state because the pair is disabled), S_PD_DRV and S_PD_FLT (powered down, driven or floating), S_HALT_DRV and S_HALT_FLT (stopped, driven or floating), and S_RUN. The machine moves only on the clock edge where the true side of the toggling clock falls. At that edge it goes to the state chosen by priority: disable, then powerdown, then stop on a pair not marked free-running, else run. As a result, no transition cuts a clock pulse short. Three further pin and register pairs (loop bandwidth, PLL or bypass, active-low divide-by-2) are combined by AND and passed out.

Top module: `clkpair_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every pair reports code 2'b10 (tri-state) with its drive output low.
- R2: With strap `strap_inv_i` = 0, enable pins are active high and powerdown and stop pins are active low. With the strap at 1, all three active levels are reversed.
- R3: A pair can leave tri-state only when both its enable pin (after polarity) and its register enable bit are 1. Any other combination gives code 2'b10 with drive low, regardless of stop or powerdown.
- R4: A change on an enable pin changes that pair's code after at least 4 and at most 12 `clk` edges (2 to 6 output clock periods).
- R5: A stop request that is active for only one `clk` cycle is ignored, and every running pair keeps code 2'b00.
- R6: An accepted stop halts only enabled pairs whose free-running bit is 0. Pairs whose bit is 1 stay at code 2'b00 and keep toggling.
- R7: A halted pair reports code 2'b01 (true 1, complement 0, drive 1) when `reg_stop_float_i` = 0, and code 2'b10 (drive 0) when it is 1.
- R8: An accepted powerdown affects every enabled pair, including free-running ones, and takes priority over stop. The pair reports code 2'b01 when `reg_pd_float_i` = 0 and code 2'b10 when it is 1.
- R9: A pair's code changes only on a `clk` edge where the toggling true side falls, that is, when the true side was 1 in the cycle before the edge.
- R10: In code 2'b00 the true side inverts on every `clk` edge, the complement side is always its inverse, and drive is 1.
- R11: `bw_o`, `pll_o` and `div2_n_o` each equal the AND of their pin input and their register bit. `div2_n_o` is active low: 0 selects divide by 2.
- R12: The per-pair code `pair_code_o[2i+1:2i]` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock; the output clock phase toggles on each edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_inv_i | input | 1 | Polarity strap for enable, powerdown and stop pins |
| oe_pin_i | input | N | Per-pair enable pins |
| pwrdn_pin_i | input | 1 | Powerdown request pin |
| stop_pin_i | input | 1 | Stop request pin |
| reg_oe_i | input | N | Per-pair register enable bits |
| reg_free_i | input | N | Per-pair free-running bits (1 = ignore stop) |
| reg_stop_float_i | input | 1 | 1 = halted pairs float, 0 = driven |
| reg_pd_float_i | input | 1 | 1 = powered-down pairs float, 0 = driven |
| bw_pin_i | input | 1 | Bandwidth select pin |
| reg_bw_i | input | 1 | Bandwidth select register bit |
| pll_pin_i | input | 1 | PLL/bypass pin (1 = PLL) |
| reg_pll_i | input | 1 | PLL/bypass register bit |
| div2_n_pin_i | input | 1 | Divide-by-2 pin, active low |
| reg_div2_n_i | input | 1 | Divide-by-2 register bit, active low |
| pair_true_o | output | N | True-side level per pair |
| pair_comp_o | output | N | Complement-side level per pair |
| pair_drive_o | output | N | 1 = pair driven, 0 = tri-state |
| pair_code_o | output | 2N | Per-pair code: 00 run, 01 stopped-driven, 10 tri-state |
| bw_o | output | 1 | Combined bandwidth select |
| pll_o | output | 1 | Combined PLL/bypass select |
| div2_n_o | output | 1 | Combined divide-by-2, active low |

## Verification
Stop and powerdown can be accepted on the same complement-clock edge, and both can land together with a disabled pair. In that case the priority order alone decides the code. The bench sweeps every combination of powerdown, stop and the float selection under both strap settings. Eight pairs carry all eight mixes of enable pin, register enable and free-running bit, so every collision occurs on some pair in one configuration, and each code is judged against an expected value computed from the priority order. A separate run toggles stop while monitoring a halting pair and a free-running reference pair. It checks that every code change follows a cycle in which the reference true side was high.

// File: rtl/clkpair_pkg.sv
package clkpair_pkg;

    typedef enum logic [2:0] {
        S_OFF      = 3'd0,
        S_PD_DRV   = 3'd1,
        S_PD_FLT   = 3'd2,
        S_HALT_DRV = 3'd3,
        S_HALT_FLT = 3'd4,
        S_RUN      = 3'd5
    } pair_state_e;

    localparam logic [1:0] CODE_RUN = 2'b00;
    localparam logic [1:0] CODE_DRV = 2'b01;
    localparam logic [1:0] CODE_OFF = 2'b10;

endpackage

// File: rtl/clkpair_sync.sv
module clkpair_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] rst_val_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= rst_val_i;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkpair_debounce.sv
module clkpair_debounce (
    input  logic clk,
    input  logic rst_n,
    input  logic cedge_i,
    input  logic req_i,
    output logic acc_o
);
    logic smp_q;
    logic acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            acc_q <= 1'b0;
        end else if (cedge_i) begin
            smp_q <= req_i;
            if (req_i == smp_q) acc_q <= req_i;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/clkpair_lane.sv
module clkpair_lane
    import clkpair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cedge_i,
    input  logic       phase_i,
    input  logic       en_i,
    input  logic       pd_i,
    input  logic       stop_i,
    input  logic       free_i,
    input  logic       stop_float_i,
    input  logic       pd_float_i,
    output logic       true_o,
    output logic       comp_o,
    output logic       drive_o,
    output logic [1:0] code_o
);
    pair_state_e state_q, state_d, target;

    always_comb begin
        if (!en_i)
            target = S_OFF;
        else if (pd_i)
            target = pd_float_i ? S_PD_FLT : S_PD_DRV;
        else if (stop_i && !free_i)
            target = stop_float_i ? S_HALT_FLT : S_HALT_DRV;
        else
            target = S_RUN;
        state_d = cedge_i ? target : state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        true_o  = 1'b0;
        comp_o  = 1'b0;
        drive_o = 1'b0;
        code_o  = CODE_OFF;
        unique case (state_q)
            S_RUN: begin
                true_o  = phase_i;
                comp_o  = ~phase_i;
                drive_o = 1'b1;
                code_o  = CODE_RUN;
            end
            S_HALT_DRV, S_PD_DRV: begin
                true_o  = 1'b1;
                drive_o = 1'b1;
                code_o  = CODE_DRV;
            end
            S_HALT_FLT, S_PD_FLT, S_OFF: begin
                code_o  = CODE_OFF;
            end
            default: code_o = CODE_OFF;
        endcase
    end
endmodule

// File: rtl/clkpair_ctrl.sv
module clkpair_ctrl #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_inv_i,
    input  logic [N-1:0]   oe_pin_i,
    input  logic           pwrdn_pin_i,
    input  logic           stop_pin_i,
    input  logic [N-1:0]   reg_oe_i,
    input  logic [N-1:0]   reg_free_i,
    input  logic           reg_stop_float_i,
    input  logic           reg_pd_float_i,
    input  logic           bw_pin_i,
    input  logic           reg_bw_i,
    input  logic           pll_pin_i,
    input  logic           reg_pll_i,
    input  logic           div2_n_pin_i,
    input  logic           reg_div2_n_i,
    output logic [N-1:0]   pair_true_o,
    output logic [N-1:0]   pair_comp_o,
    output logic [N-1:0]   pair_drive_o,
    output logic [2*N-1:0] pair_code_o,
    output logic           bw_o,
    output logic           pll_o,
    output logic           div2_n_o
);
    localparam int SW = N + 2;

    logic          phase_q;
    logic          cedge;
    logic [SW-1:0] req_raw, req_sync;
    logic [N-1:0]  oe_q1, oe_q2;
    logic          stop_acc, pd_acc;

    // Output clock phase; the complement rises when the true side falls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end
    assign cedge = phase_q;

    // Polarity: request bits are 1 when active.
    assign req_raw[N-1:0] = oe_pin_i ^ {N{strap_inv_i}};
    assign req_raw[N]     = ~(stop_pin_i  ^ strap_inv_i);
    assign req_raw[N+1]   = ~(pwrdn_pin_i ^ strap_inv_i);

    clkpair_sync #(.W(SW), .STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       (req_raw),
        .rst_val_i ({SW{1'b0}}),
        .q_o       (req_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q1 <= '0;
            oe_q2 <= '0;
        end else if (cedge) begin
            oe_q1 <= req_sync[N-1:0];
            oe_q2 <= oe_q1;
        end
    end

    clkpair_debounce u_db_stop (
        .clk(clk), .rst_n(rst_n), .cedge_i(cedge),
        .req_i(req_sync[N]), .acc_o(stop_acc)
    );
    clkpair_debounce u_db_pd (
        .clk(clk), .rst_n(rst_n), .cedge_i(cedge),
        .req_i(req_sync[N+1]), .acc_o(pd_acc)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        clkpair_lane u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .cedge_i      (cedge),
            .phase_i      (phase_q),
            .en_i         (oe_q2[i] & reg_oe_i[i]),
            .pd_i         (pd_acc),
            .stop_i       (stop_acc),
            .free_i       (reg_free_i[i]),
            .stop_float_i (reg_stop_float_i),
            .pd_float_i   (reg_pd_float_i),
            .true_o       (pair_true_o[i]),
            .comp_o       (pair_comp_o[i]),
            .drive_o      (pair_drive_o[i]),
            .code_o       (pair_code_o[2*i +: 2])
        );
    end

    assign bw_o     = bw_pin_i     & reg_bw_i;
    assign pll_o    = pll_pin_i    & reg_pll_i;
    assign div2_n_o = div2_n_pin_i & reg_div2_n_i;
endmodule

// File: rtl/clkpair_ctrl_chk.sv
module clkpair_ctrl_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           phase_q,
    input logic           stop_acc,
    input logic [N-1:0]   pair_true_o,
    input logic [N-1:0]   pair_comp_o,
    input logic [N-1:0]   pair_drive_o,
    input logic [2*N-1:0] pair_code_o
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        // R12
        code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_code_o[2*i +: 2] != 2'b11);

        // R9
        change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_code_o[2*i +: 2] != $past(pair_code_o[2*i +: 2])) |-> $past(phase_q));

        // R10
        run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_code_o[2*i +: 2] == 2'b00 && $past(pair_code_o[2*i +: 2]) == 2'b00)
            |-> (pair_true_o[i] != $past(pair_true_o[i]) && pair_comp_o[i] == ~pair_true_o[i]));

        // R7
        held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_code_o[2*i +: 2] == 2'b01)
            |-> (pair_true_o[i] && !pair_comp_o[i] && pair_drive_o[i]));
    end

    // R5
    stop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_acc != $past(stop_acc)) |-> $past(phase_q));
endmodule

bind clkpair_ctrl clkpair_ctrl_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_q      (phase_q),
    .stop_acc     (stop_acc),
    .pair_true_o  (pair_true_o),
    .pair_comp_o  (pair_comp_o),
    .pair_drive_o (pair_drive_o),
    .pair_code_o  (pair_code_o)
);

// File: tb/clkpair_ctrl_test.sv
module clkpair_ctrl_test;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           strap_inv_i = 1'b0;
    logic [N-1:0]   oe_pin_i = '0;
    logic           pwrdn_pin_i = 1'b1;
    logic           stop_pin_i = 1'b1;
    logic [N-1:0]   reg_oe_i = '0;
    logic [N-1:0]   reg_free_i = '0;
    logic           reg_stop_float_i = 1'b0;
    logic           reg_pd_float_i = 1'b0;
    logic           bw_pin_i = 1'b0, reg_bw_i = 1'b0;
    logic           pll_pin_i = 1'b0, reg_pll_i = 1'b0;
    logic           div2_n_pin_i = 1'b0, reg_div2_n_i = 1'b0;
    logic [N-1:0]   pair_true_o, pair_comp_o, pair_drive_o;
    logic [2*N-1:0] pair_code_o;
    logic           bw_o, pll_o, div2_n_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    clkpair_ctrl #(.N(N)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] code(input int i);
        return pair_code_o[2*i +: 2];
    endfunction

    // Lane i: enable pin (logical) = i[0], register enable = i[1], free = i[2].
    task automatic setup_lanes(input bit strap);
        strap_inv_i = strap;
        for (int i = 0; i < N; i++) begin
            oe_pin_i[i]   = (i[0] != 0) ^ strap;
            reg_oe_i[i]   = (i[1] != 0);
            reg_free_i[i] = (i[2] != 0);
        end
    endtask

    task automatic check_pair(input int i, input logic [1:0] exp, input string req);
        logic t0;
        chk(code(i) == exp, req, code(i), exp);
        if (exp == 2'b10) chk(pair_drive_o[i] == 1'b0, "R3 drive", pair_drive_o[i], 0);
        if (exp == 2'b01) chk(pair_true_o[i] && !pair_comp_o[i] && pair_drive_o[i],
                              "R7 driven levels", {pair_true_o[i], pair_comp_o[i]}, 2);
        if (exp == 2'b00) begin
            t0 = pair_true_o[i];
            @(negedge clk);
            chk(pair_true_o[i] != t0 && pair_comp_o[i] == ~pair_true_o[i] && pair_drive_o[i],
                "R10 toggle", pair_true_o[i], !t0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp;
        int cnt;
        logic prev_ref;
        logic [1:0] prev_code;

        // R1: reset state
        setup_lanes(1'b0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(code(i) == 2'b10 && !pair_drive_o[i], "R1 in reset", code(i), 2);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk(code(i) == 2'b10 && !pair_drive_o[i], "R1 after reset", code(i), 2);

        // R2 R3 R6 R7 R8: sweep strap x {pd, stop, float}
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 8; m++) begin
                bit pd_a, st_a, fl;
                pd_a = m[2]; st_a = m[1]; fl = m[0];
                setup_lanes(s[0]);
                pwrdn_pin_i      = pd_a ? s[0] : ~s[0];
                stop_pin_i       = st_a ? s[0] : ~s[0];
                reg_stop_float_i = fl;
                reg_pd_float_i   = fl;
                repeat (24) @(negedge clk);
                for (int i = 0; i < N; i++) begin
                    if (!(i[0] && i[1]))      exp = 2'b10;
                    else if (pd_a)            exp = fl ? 2'b10 : 2'b01;
                    else if (st_a && !i[2])   exp = fl ? 2'b10 : 2'b01;
                    else                      exp = 2'b00;
                    check_pair(i, exp, pd_a ? "R8 pd" : (st_a ? "R6 stop" : "R2 R3 enable"));
                end
            end
        end

        // R4: enable pin latency, lane 3 running, strap 0
        setup_lanes(1'b0);
        pwrdn_pin_i = 1'b1; stop_pin_i = 1'b1;
        repeat (24) @(negedge clk);
        oe_pin_i[3] = 1'b0;
        cnt = 0;
        while (code(3) == 2'b00 && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt >= 4 && cnt <= 12, "R4 disable latency", cnt, 8);
        oe_pin_i[3] = 1'b1;
        cnt = 0;
        while (code(3) != 2'b00 && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt >= 4 && cnt <= 12, "R4 enable latency", cnt, 8);

        // R5: one-cycle stop glitch ignored
        repeat (6) @(negedge clk);
        stop_pin_i = 1'b0;
        @(negedge clk);
        stop_pin_i = 1'b1;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            chk(code(3) == 2'b00, "R5 glitch ignored", code(3), 0);
        end

        // R9: stop entry/exit aligned to true falling edge (lane 7 is the reference)
        reg_stop_float_i = 1'b0;
        for (int r = 0; r < 6; r++) begin
            stop_pin_i = r[0] ? 1'b1 : 1'b0;
            @(negedge clk);
            for (int k = 0; k < 3 + r; k++) @(negedge clk);
            for (int k = 0; k < 16; k++) begin
                prev_ref  = pair_true_o[7];
                prev_code = code(3);
                @(negedge clk);
                if (code(3) != prev_code)
                    chk(prev_ref == 1'b1, "R9 aligned change", prev_ref, 1);
            end
            chk(code(3) == (r[0] ? 2'b00 : 2'b01), "R9 final state", code(3), r[0] ? 0 : 1);
        end

        // R11: combined selects
        for (int v = 0; v < 64; v++) begin
            {bw_pin_i, reg_bw_i, pll_pin_i, reg_pll_i, div2_n_pin_i, reg_div2_n_i} = v[5:0];
            #1;
            chk(bw_o == (v[5] & v[4]) && pll_o == (v[3] & v[2]) && div2_n_o == (v[1] & v[0]),
                "R11 AND", {bw_o, pll_o, div2_n_o},
                {v[5] & v[4], v[3] & v[2], v[1] & v[0]});
        end

        // R12: code legality over all lanes
        for (int i = 0; i < N; i++)
            chk(code(i) != 2'b11, "R12 legal code", code(i), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule